// File: doc/BRIEF.md
# MSI Capture Ring Writer

The block receives message-signalled interrupt writes that have already been decoded to a 32-bit interrupt number. It turns each one into a 16-byte record that it writes into a circular buffer in host memory. The buffer base, the ring size and the policies are set through a small word-addressed register port. Software consumes records by moving a read offset. The block advances its own write offset after every record that memory accepts.

The write offset counts freely and does not wrap. The ring position of a record is that counter masked to the ring size, with the low four bits cleared. Software applies the same mask when it reads the counter. A four-deep input queue absorbs bursts of incoming interrupts. Only one memory write is in flight at any time. An interrupt line tells the host that records are pending or that the ring filled up.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset every register reads zero: control (0x0), drop count (0x1), base high (0x3), base low (0x4), read offset (0x5) and write offset (0x6). In the same state `irq` and `mem_valid` are low and `msi_ready` is high.
- R2: A record goes to address {base_high, base_low} + (write offset AND mask). Data bits 31:0 carry the interrupt number, so byte 0 holds its least significant byte. Data bits 127:32 are zero. The mask is (2^(15+k) − 1) with bits 3:0 cleared, where k is control bits 9:8.
- R3: Each accepted memory write adds 16 to the write offset register. The register is never reduced modulo the ring size. It does not change otherwise.
- R4: `irq` = capture enable (control bit 0) AND interrupt enable (bit 3) AND (masked write offset ≠ masked read offset, OR the sticky full flag together with full-indication enable, bit 1). Writing the read offset equal to the write offset removes the pending term.
- R5: The ring is full when (write offset + 16) masked equals the masked read offset. With stop-on-full (bit 4) set, an interrupt that arrives while the ring is full is discarded without a memory write, and the drop count register increments.
- R6: With stop-on-full clear, an interrupt that arrives while the ring is full is still written, and the write offset advances.
- R7: When full-indication enable is set, a full condition sets sticky control bit 15. Writing 1 to bit 15 clears it. Writing 0 leaves it unchanged.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady. A new request starts only after the previous one is accepted.
- R9: The input queue holds four interrupts. `msi_ready` goes low while it is full.
- R10: While capture enable is clear, queued interrupts are discarded. No memory write occurs and the write offset does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| msi_valid | input | 1 | Inbound interrupt present |
| msi_num | input | 32 | Inbound interrupt number |
| msi_ready | output | 1 | Input queue can accept |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | Record contents |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| irq | output | 1 | Interrupt to the host |

## Verification
An interrupt that is accepted on one edge is popped on the next edge. Its memory request is raised right after that second edge. The write offset moves on the edge where `mem_ready` meets `mem_valid`, and `irq` follows combinationally from the registered offsets. The monitor compares each request against the scoreboard queue at the falling edge, so both handshake signals are stable when they are sampled. Register and `irq` checks run only after the bench has waited for the scoreboard to drain plus a few idle cycles. A record that is dropped or discarded is therefore already resolved when these checks sample.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
   localparam int REG_AW      = 3;
   localparam int REG_DW      = 32;
   localparam int ENTRY_BYTES = 16;
   localparam int SIZE_BASE   = 15;

   typedef enum logic [REG_AW-1:0] {
      RA_CTRL  = 3'd0,
      RA_DROPS = 3'd1,
      RA_BASEH = 3'd3,
      RA_BASEL = 3'd4,
      RA_RDOFF = 3'd5,
      RA_WROFF = 3'd6
   } reg_addr_e;

   function automatic logic [31:0] ring_mask(input logic [1:0] k);
      logic [31:0] span;
      span = 32'd1 << (SIZE_BASE + int'(k));
      return (span - 32'd1) & ~32'(ENTRY_BYTES - 1);
   endfunction
endpackage

// File: rtl/msi_ring_queue.sv
module msi_ring_queue #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   output logic             can_push,
   input  logic             pop,
   output logic             has_data,
   output logic [WIDTH-1:0] head
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("msi_ring_queue: DEPTH must be a power of two and at least 2");
   end

   logic [WIDTH-1:0] slots [DEPTH];
   logic [PW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign can_push = (cnt != CW'(DEPTH));
   assign has_data = (cnt != '0);
   assign head     = slots[rp];
   assign do_push  = push && can_push;
   assign do_pop   = pop && has_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + PW'(1);
         if (do_pop)  rp <= rp + PW'(1);
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slots[wp] <= push_data;
   end

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(DEPTH) && !pop) |=> (cnt == CW'(DEPTH)));
   a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
endmodule

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
   import msi_ring_pkg::*;
#(
   parameter int MEM_AW = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic [31:0]       wr_off,
   input  logic [31:0]       drop_cnt,
   input  logic              full_evt,
   output logic              cap_en,
   output logic              full_en,
   output logic              irq_en,
   output logic              stop_en,
   output logic [1:0]        size_k,
   output logic [MEM_AW-1:0] base,
   output logic [31:0]       rd_off,
   output logic              irq
);
   logic [31:0] base_hi, base_lo;
   logic        sticky;
   logic [31:0] mask;
   logic        wr_ctrl;

   assign base    = MEM_AW'({base_hi, base_lo});
   assign mask    = ring_mask(size_k);
   assign wr_ctrl = reg_we && reg_addr == RA_CTRL;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {cap_en, full_en, irq_en, stop_en, sticky} <= '0;
         size_k  <= '0;
         base_hi <= '0;
         base_lo <= '0;
         rd_off  <= '0;
      end else begin
         if (wr_ctrl) begin
            cap_en  <= reg_wdata[0];
            full_en <= reg_wdata[1];
            irq_en  <= reg_wdata[3];
            stop_en <= reg_wdata[4];
            size_k  <= reg_wdata[9:8];
         end
         if (full_evt && full_en)          sticky <= 1'b1;
         else if (wr_ctrl && reg_wdata[15]) sticky <= 1'b0;
         if (reg_we && reg_addr == RA_BASEH) base_hi <= reg_wdata;
         if (reg_we && reg_addr == RA_BASEL) base_lo <= reg_wdata;
         if (reg_we && reg_addr == RA_RDOFF)
            rd_off <= reg_wdata & ~32'(ENTRY_BYTES - 1);
      end
   end

   always_comb begin
      unique case (reg_addr)
         RA_CTRL:  reg_rdata = {16'd0, sticky, 5'd0, size_k, 3'd0,
                                stop_en, irq_en, 1'b0, full_en, cap_en};
         RA_DROPS: reg_rdata = drop_cnt;
         RA_BASEH: reg_rdata = base_hi;
         RA_BASEL: reg_rdata = base_lo;
         RA_RDOFF: reg_rdata = rd_off;
         RA_WROFF: reg_rdata = wr_off;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq = cap_en && irq_en &&
                (((wr_off & mask) != (rd_off & mask)) || (sticky && full_en));

   a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_en && irq_en) |-> !irq);
   a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky && !wr_ctrl) |=> sticky);
endmodule

// File: rtl/msi_ring_engine.sv
module msi_ring_engine
   import msi_ring_pkg::*;
#(
   parameter int MEM_AW = 64,
   parameter int MEM_DW = 128,
   parameter int NUM_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              stop_en,
   input  logic [1:0]        size_k,
   input  logic [MEM_AW-1:0] base,
   input  logic [31:0]       rd_off,
   input  logic              q_valid,
   input  logic [NUM_W-1:0]  q_num,
   output logic              q_pop,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [MEM_DW-1:0] mem_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [31:0]       wr_off,
   output logic [31:0]       drop_cnt,
   output logic              full_evt
);
   if (MEM_DW < NUM_W || MEM_DW != ENTRY_BYTES * 8) begin : g_bad_width
      $error("msi_ring_engine: MEM_DW must equal the record size in bits");
   end

   logic [31:0] mask;
   logic        is_full, accept, busy;

   assign mask      = ring_mask(size_k);
   assign is_full   = ((wr_off + 32'(ENTRY_BYTES)) & mask) == (rd_off & mask);
   assign q_pop     = q_valid && !busy;
   assign full_evt  = q_pop && cap_en && is_full;
   assign accept    = q_pop && cap_en && !(is_full && stop_en);
   assign mem_valid = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         wr_off   <= '0;
         drop_cnt <= '0;
         mem_addr <= '0;
         mem_data <= '0;
      end else begin
         if (accept) begin
            busy     <= 1'b1;
            mem_addr <= base + MEM_AW'(wr_off & mask);
            mem_data <= MEM_DW'(q_num);
         end else if (busy && mem_ready) begin
            busy   <= 1'b0;
            wr_off <= wr_off + 32'(ENTRY_BYTES);
         end
         if (full_evt && stop_en) drop_cnt <= drop_cnt + 32'd1;
      end
   end

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=>
         (mem_valid && $stable(mem_addr) && $stable(mem_data)));
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready) |=> (wr_off == $past(wr_off) + 32'd16));
   a_r3_still: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_valid && mem_ready) |=> $stable(wr_off));
   a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr[3:0] == base[3:0]));
   a_r5_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (full_evt && stop_en) |=> !mem_valid);
   a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (q_pop && !cap_en) |=> !mem_valid);
endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
   import msi_ring_pkg::*;
#(
   parameter int MEM_AW  = 64,
   parameter int MEM_DW  = 128,
   parameter int NUM_W   = 32,
   parameter int Q_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic              msi_valid,
   input  logic [NUM_W-1:0]  msi_num,
   output logic              msi_ready,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [MEM_DW-1:0] mem_data,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              irq
);
   logic              cap_en, full_en, irq_en, stop_en, full_evt;
   logic [1:0]        size_k;
   logic [MEM_AW-1:0] base;
   logic [31:0]       rd_off, wr_off, drop_cnt;
   logic              q_valid, q_pop;
   logic [NUM_W-1:0]  q_num;

   msi_ring_queue #(.WIDTH(NUM_W), .DEPTH(Q_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(msi_valid), .push_data(msi_num), .can_push(msi_ready),
      .pop(q_pop), .has_data(q_valid), .head(q_num)
   );

   msi_ring_regs #(.MEM_AW(MEM_AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .wr_off(wr_off), .drop_cnt(drop_cnt), .full_evt(full_evt),
      .cap_en(cap_en), .full_en(full_en), .irq_en(irq_en),
      .stop_en(stop_en), .size_k(size_k), .base(base), .rd_off(rd_off),
      .irq(irq)
   );

   msi_ring_engine #(.MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .NUM_W(NUM_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .cap_en(cap_en), .stop_en(stop_en), .size_k(size_k), .base(base),
      .rd_off(rd_off),
      .q_valid(q_valid), .q_num(q_num), .q_pop(q_pop),
      .mem_addr(mem_addr), .mem_data(mem_data), .mem_valid(mem_valid),
      .mem_ready(mem_ready),
      .wr_off(wr_off), .drop_cnt(drop_cnt), .full_evt(full_evt)
   );

   a_r9_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> msi_ready);
endmodule

// File: tb/sim_msi_ring_writer.sv
module sim_msi_ring_writer;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic         reg_we = 1'b0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         msi_valid = 1'b0;
   logic [31:0]  msi_num = '0;
   logic         msi_ready;
   logic [63:0]  mem_addr;
   logic [127:0] mem_data;
   logic         mem_valid;
   logic         mem_ready;
   logic         irq;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   msi_ring_writer u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .msi_valid(msi_valid), .msi_num(msi_num), .msi_ready(msi_ready),
      .mem_addr(mem_addr), .mem_data(mem_data), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .irq(irq)
   );

   // memory model: ready pattern from an LFSR, can be forced low
   logic [15:0] lfsr = 16'hACE1;
   logic        hold_low = 1'b0;
   always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   assign mem_ready = !hold_low && (lfsr[0] || lfsr[1]);

   // scoreboard
   logic [63:0]  exp_addr_q[$];
   logic [127:0] exp_data_q[$];
   logic [63:0]  base_m = '0;
   logic [31:0]  exp_wr = '0;
   logic [1:0]   cur_k = '0;

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mmask(input logic [1:0] k);
      return ((32'd1 << (15 + int'(k))) - 32'd1) & ~32'hF;
   endfunction

   task automatic expect_entry(input logic [31:0] num);
      exp_addr_q.push_back(base_m + 64'(exp_wr & mmask(cur_k)));
      exp_data_q.push_back({96'd0, num});
      exp_wr += 32'd16;
   endtask

   always @(negedge clk) begin
      if (rst_n && mem_valid && mem_ready) begin
         if (exp_addr_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R10/R5 unexpected write actual=%0h expected=none", mem_addr);
         end else begin
            check("R2 addr", 128'(mem_addr), 128'(exp_addr_q.pop_front()));
            check("R2 data", mem_data, exp_data_q.pop_front());
         end
      end
   end

   task automatic wreg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic send(input logic [31:0] n);
      @(negedge clk);
      while (!msi_ready) @(negedge clk);
      msi_valid = 1'b1; msi_num = n;
      @(negedge clk);
      msi_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_addr_q.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      foreach (u_addrs[i]) begin
         rreg(u_addrs[i], v);
         check("R1 reg", 128'(v), 128'd0);
      end
      check("R1 irq", 128'(irq), 128'd0);
      check("R1 mem_valid", 128'(mem_valid), 128'd0);
      check("R1 msi_ready", 128'(msi_ready), 128'd1);

      // R10 capture disabled: discarded
      send(32'h55);
      repeat (10) @(negedge clk);
      rreg(3'd6, v);
      check("R10 wr_off unchanged", 128'(v), 128'd0);

      // basic capture, k=1
      base_m = 64'h1_8000_0000;
      cur_k = 2'd1;
      wreg(3'd3, 32'h1);
      wreg(3'd4, 32'h8000_0000);
      wreg(3'd0, 32'h0109);
      for (int i = 0; i < 3; i++) begin
         expect_entry(32'h100 + 32'(i));
         send(32'h100 + 32'(i));
      end
      drain();
      rreg(3'd6, v);
      check("R3 wr_off", 128'(v), 128'h30);
      check("R4 irq pending", 128'(irq), 128'd1);
      wreg(3'd5, 32'h30);
      @(negedge clk);
      check("R4 irq cleared by rd_off", 128'(irq), 128'd0);

      // R9 queue back-pressure
      hold_low = 1'b1;
      for (int i = 0; i < 5; i++) begin
         expect_entry(32'h200 + 32'(i));
         send(32'h200 + 32'(i));
      end
      check("R9 msi_ready low when full", 128'(msi_ready), 128'd0);
      hold_low = 1'b0;
      drain();
      rreg(3'd6, v);
      check("R3 wr_off after burst", 128'(v), 128'h80);

      // R5 stop-on-full, R7 sticky
      wreg(3'd0, 32'h011B);
      wreg(3'd5, 32'hA0);
      expect_entry(32'hA);
      send(32'hA);
      send(32'hB);
      drain();
      rreg(3'd6, v);
      check("R5 wr_off after drop", 128'(v), 128'h90);
      rreg(3'd1, v);
      check("R5 drop count", 128'(v), 128'd1);
      rreg(3'd0, v);
      check("R7 sticky set", 128'(v), 128'h811B);
      wreg(3'd5, 32'h90);
      @(negedge clk);
      check("R4 irq from sticky", 128'(irq), 128'd1);
      wreg(3'd0, 32'h011B);
      rreg(3'd0, v);
      check("R7 write 0 keeps sticky", 128'(v), 128'h811B);
      wreg(3'd0, 32'h811B);
      rreg(3'd0, v);
      check("R7 sticky cleared", 128'(v), 128'h011B);
      check("R4 irq idle", 128'(irq), 128'd0);

      // R6 overwrite when full without stop
      wreg(3'd0, 32'h010B);
      wreg(3'd5, 32'hB0);
      expect_entry(32'hC);
      send(32'hC);
      expect_entry(32'hD);
      send(32'hD);
      drain();
      rreg(3'd6, v);
      check("R6 written while full", 128'(v), 128'hB0);
      rreg(3'd0, v);
      check("R7 sticky on full", 128'(v), 128'h810B);
      rreg(3'd1, v);
      check("R6 no drop", 128'(v), 128'd1);

      // R3 free-running offset, k=0 wraps at 32 KB
      wreg(3'd0, 32'h8001);
      cur_k = 2'd0;
      for (int i = 0; i < 2100; i++) begin
         expect_entry(32'h1000 + 32'(i));
         send(32'h1000 + 32'(i));
      end
      drain();
      rreg(3'd6, v);
      check("R3 unwrapped offset", 128'(v), 128'h83F0);
      check("R4 irq off without irq enable", 128'(irq), 128'd0);

      wreg(3'd0, 32'h0);
      check("R4 irq off when disabled", 128'(irq), 128'd0);
      finish_run();
   end

   logic [2:0] u_addrs [6] = '{3'd0, 3'd1, 3'd3, 3'd4, 3'd5, 3'd6};
endmodule